// File: doc/BRIEF.md
# Click-Free Stereo Gain Ramp Controller

This block scales two channels of signed PCM audio by a per-channel digital gain expressed in half-decibel codes. Each channel has its own target gain input, and the block keeps its own record of the gain it is actually applying. On every input sample strobe that applied gain moves toward the target in the way a shared two-bit mode selects. The change can land at once, wait for a zero crossing of that channel's signal, ramp by one code per sample, or ramp one code at a time with each step taken only at a zero crossing. Because the step lands where the waveform is near zero, or is made small, the output has no audible discontinuities.

The scaled samples come out one clock after the strobe, each marked by an output valid pulse. The gain used for each sample is the applied gain after that strobe's update. A settled flag reports when both channels have reached their targets. A waiting change is forced through if the signal does not cross zero within a bounded number of samples.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both applied gains are code 0, out_valid is low, both outputs are 0, and gain_settled is high while both targets are 0.
- R2: One clock after a strobe, out_valid is high and each output equals floor(sample * F(g) / 2^14), where g is that channel's applied gain after the strobe. F(0)=16384. For k>0, F(k)=floor(F(k-1)*17355/16384). For k<0, F(k)=floor(F(k+1)*15467/16384). Without a strobe, out_valid is low the next cycle.
- R3: A scaled result above 32767 or below -32768 is replaced by 32767 or -32768 respectively.
- R4: Mode 2'b00 (immediate): on each strobe the applied gain becomes the target.
- R5: Mode 2'b01 (zero-cross): on a strobe whose sample is zero, or whose sign differs from that channel's previous strobed sample, the applied gain jumps to the target. The previous sample is taken as non-negative after reset.
- R6: In the modes with bit 0 set, when a change has waited TIMEOUT consecutive strobes without a crossing, it is taken on the TIMEOUT-th strobe. The wait count restarts after every step taken and whenever the gain is settled.
- R7: Mode 2'b10 (ramp): on each strobe the applied gain moves one code toward the target.
- R8: Mode 2'b11 (ramp at crossings): the applied gain moves one code toward the target only on a crossing strobe, or on a timeout as in R6.
- R9: Gain codes are 6-bit two's complement. A target beyond +/-MAX_CODE (default 24, i.e. +/-12 dB) is treated as the nearest limit.
- R10: Changing the target during a ramp continues the ramp from the present applied gain toward the new target.
- R11: The two channels keep separate applied gains, crossing histories and wait counts.
- R12: The applied gains change only on strobes. gain_settled is high exactly when each applied gain equals its clamped target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Gain change mode: bit 1 ramp, bit 0 wait for crossing |
| tgt_a | input | 6 | Target gain code, channel A |
| tgt_b | input | 6 | Target gain code, channel B |
| in_valid | input | 1 | Sample strobe |
| in_a | input | 16 | Input sample, channel A |
| in_b | input | 16 | Input sample, channel B |
| out_valid | output | 1 | Scaled samples valid |
| out_a | output | 16 | Scaled sample, channel A |
| out_b | output | 16 | Scaled sample, channel B |
| cur_a | output | 6 | Applied gain code, channel A |
| cur_b | output | 6 | Applied gain code, channel B |
| gain_settled | output | 1 | Both applied gains equal their targets |

## Verification
A gain step and saturation can fall on the same strobe. Sample and gain code interact there, because the output must use the freshly stepped gain, and at high codes full-scale samples push the product past the limits. The bench provokes this with an immediate-mode sweep over every code, paired with full-scale, small and zero samples. In the crossing modes a crossing and a timeout expiry can also coincide. Long same-sign runs are followed by sign flips, and a per-channel model, computed from the requirements, judges each strobe's gain and scaled output.

// File: rtl/gain_ramp_pkg.sv
// Shared definitions for the gain ramp controller.
// Assumes gain factors are unsigned fixed point with FRAC_W fraction bits.
package gain_ramp_pkg;
    typedef enum logic [1:0] {
        GM_IMMEDIATE  = 2'b00,
        GM_ZEROX      = 2'b01,
        GM_RAMP       = 2'b10,
        GM_RAMP_ZEROX = 2'b11
    } gain_mode_e;

    localparam int FRAC_W = 14;      // fraction bits of the linear factor
    localparam int UP_K   = 17355;   // +0.5 dB multiplier in FRAC_W fixed point
    localparam int DN_K   = 15467;   // -0.5 dB multiplier in FRAC_W fixed point
endpackage

// File: rtl/gr_zero_cross.sv
// Zero-crossing detector for one channel.
// Flags a crossing when the strobed sample is zero or its sign differs from
// the previous strobed sample. Assumes the history resets to non-negative.
module gr_zero_cross #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zc
);
    localparam int MSB = SAMPLE_W - 1;

    logic prev_neg;

    // Combinational crossing decision against the remembered sign.
    always_comb begin
        zc = (sample == '0) || (sample[MSB] != prev_neg);
    end

    // Remember the sign of each strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_neg <= 1'b0;
        else if (strobe) prev_neg <= sample[MSB];
    end
endmodule

// File: rtl/gr_gain_step.sv
// Applied-gain state machine for one channel.
// Clamps the target, then steps or jumps the applied code on strobes as the
// mode selects, with a crossing-wait timeout. Assumes TIMEOUT >= 2.
module gr_gain_step
    import gain_ramp_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 24,
    parameter int TIMEOUT  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [1:0]        mode,
    input  logic [CODE_W-1:0] target,
    input  logic              zc,
    output logic [CODE_W-1:0] cur,
    output logic [CODE_W-1:0] cur_nxt,
    output logic              done
);
    localparam int CNT_W = $clog2(TIMEOUT);
    localparam logic signed [CODE_W-1:0] CMAX = CODE_W'(MAX_CODE);
    localparam logic signed [CODE_W-1:0] CMIN = -CMAX;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [CODE_W-1:0] tgt_c;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              pending;
    logic              expired;
    logic              allow;
    logic              go_up;

    // Clamp the requested target into the legal code range.
    always_comb begin
        if ($signed(target) > CMAX)      tgt_c = CMAX;
        else if ($signed(target) < CMIN) tgt_c = CMIN;
        else                             tgt_c = target;
    end

    // Decide whether a change is due on this strobe.
    always_comb begin
        pending = (cur != tgt_c);
        expired = (cnt == CNT_LAST);
        allow   = !mode[0] || zc || expired;
        go_up   = ($signed(tgt_c) > $signed(cur));
        done    = !pending;
    end

    // Next applied code: jump or single step toward the target.
    always_comb begin
        cur_nxt = cur;
        if (strobe && pending && allow) begin
            if (!mode[1])   cur_nxt = tgt_c;
            else if (go_up) cur_nxt = cur + CODE_W'(1);
            else            cur_nxt = cur - CODE_W'(1);
        end
    end

    // Next wait count: counts only while blocked waiting for a crossing.
    always_comb begin
        cnt_nxt = cnt;
        if (strobe) begin
            if (pending && mode[0] && !zc && !expired) cnt_nxt = cnt + CNT_W'(1);
            else                                       cnt_nxt = '0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            cnt <= '0;
        end else begin
            cur <= cur_nxt;
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/gr_gain_lut.sv
// Converts a signed half-decibel code into a linear factor.
// The factor table is built from repeated constant multiplications, which
// fold to constants; assumes FAC_W holds the factor of MAX_CODE.
module gr_gain_lut
    import gain_ramp_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 24,
    parameter int FAC_W    = 17
) (
    input  logic [CODE_W-1:0] code,
    output logic [FAC_W-1:0]  fac
);
    localparam logic [63:0] ONE = 64'(1) << FRAC_W;

    logic [63:0] f_up;
    logic [63:0] f_dn;

    // Walk both directions from unity and pick the matching code.
    always_comb begin
        f_up = ONE;
        f_dn = ONE;
        fac  = ONE[FAC_W-1:0];
        for (int i = 1; i <= MAX_CODE; i++) begin
            f_up = (f_up * 64'(UP_K)) >> FRAC_W;
            f_dn = (f_dn * 64'(DN_K)) >> FRAC_W;
            if (code == CODE_W'(i))  fac = f_up[FAC_W-1:0];
            if (code == CODE_W'(-i)) fac = f_dn[FAC_W-1:0];
        end
    end
endmodule

// File: rtl/gr_gain_apply.sv
// Multiplies a signed sample by an unsigned fixed-point factor, floors the
// result by the fraction width and saturates to the sample width.
module gr_gain_apply
    import gain_ramp_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FAC_W    = 17
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [FAC_W-1:0]    fac,
    output logic [SAMPLE_W-1:0] result
);
    localparam int PW = SAMPLE_W + FAC_W + 1;
    localparam logic signed [PW-1:0] SMAX = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PW-1:0] SMIN = {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic signed [PW-1:0] s_x;
    logic signed [PW-1:0] f_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;

    // Full-precision product, arithmetic shift, then clip.
    always_comb begin
        s_x  = {{(PW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
        f_x  = {{(PW-FAC_W){1'b0}}, fac};
        prod = s_x * f_x;
        shf  = prod >>> FRAC_W;
        if (shf > SMAX)      result = SMAX[SAMPLE_W-1:0];
        else if (shf < SMIN) result = SMIN[SAMPLE_W-1:0];
        else                 result = shf[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/gr_channel.sv
// One audio channel: crossing detector, gain state, factor lookup and
// registered scaled output. The output uses the gain after this strobe.
module gr_channel #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 24,
    parameter int TIMEOUT  = 512,
    parameter int FAC_W    = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [1:0]          mode,
    input  logic [CODE_W-1:0]   target,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] dout,
    output logic [CODE_W-1:0]   cur,
    output logic                done
);
    logic                zc;
    logic [CODE_W-1:0]   cur_nxt;
    logic [FAC_W-1:0]    fac;
    logic [SAMPLE_W-1:0] scaled;

    gr_zero_cross #(.SAMPLE_W(SAMPLE_W)) i_zc (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sample(sample), .zc(zc)
    );

    gr_gain_step #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .TIMEOUT(TIMEOUT)) i_step (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode), .target(target),
        .zc(zc), .cur(cur), .cur_nxt(cur_nxt), .done(done)
    );

    gr_gain_lut #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .FAC_W(FAC_W)) i_lut (
        .code(cur_nxt), .fac(fac)
    );

    gr_gain_apply #(.SAMPLE_W(SAMPLE_W), .FAC_W(FAC_W)) i_apply (
        .sample(sample), .fac(fac), .result(scaled)
    );

    // Register the scaled sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (strobe) dout <= scaled;
    end
endmodule

// File: rtl/gain_ramp_ctrl.sv
// Stereo click-free gain controller, top level.
// Replicates one channel per stereo side, registers the output strobe and
// combines the per-channel settled indications. One clock of latency.
module gain_ramp_ctrl #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 24,
    parameter int TIMEOUT  = 512,
    parameter int FAC_W    = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic [CODE_W-1:0]   tgt_a,
    input  logic [CODE_W-1:0]   tgt_b,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_a,
    input  logic [SAMPLE_W-1:0] in_b,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_a,
    output logic [SAMPLE_W-1:0] out_b,
    output logic [CODE_W-1:0]   cur_a,
    output logic [CODE_W-1:0]   cur_b,
    output logic                gain_settled
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0][SAMPLE_W-1:0] din;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] dout;
    logic [NUM_CH-1:0][CODE_W-1:0]   tgt;
    logic [NUM_CH-1:0][CODE_W-1:0]   cur;
    logic [NUM_CH-1:0]               done;

    // Gather the per-channel ports into arrays.
    always_comb begin
        din[0] = in_a;
        din[1] = in_b;
        tgt[0] = tgt_a;
        tgt[1] = tgt_b;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gr_channel #(
            .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
            .TIMEOUT(TIMEOUT), .FAC_W(FAC_W)
        ) i_chan (
            .clk(clk), .rst_n(rst_n), .strobe(in_valid), .mode(mode),
            .target(tgt[ch]), .sample(din[ch]), .dout(dout[ch]),
            .cur(cur[ch]), .done(done[ch])
        );
    end

    // Drive the per-channel outputs and the combined settled flag.
    always_comb begin
        out_a        = dout[0];
        out_b        = dout[1];
        cur_a        = cur[0];
        cur_b        = cur[1];
        gain_settled = &done;
    end

    // Output strobe follows the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/gain_ramp_ctrl_chk.sv
// Property checker for gain_ramp_ctrl, bound to every instance.
module gain_ramp_ctrl_chk #(
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [CODE_W-1:0] tgt_a,
    input logic              in_valid,
    input logic              out_valid,
    input logic [CODE_W-1:0] cur_a,
    input logic [CODE_W-1:0] cur_b
);
    // R2: output strobe tracks the input strobe one clock later.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: immediate mode lands an in-range target in one strobe.
    p_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && $signed(tgt_a) <= MAX_CODE
         && $signed(tgt_a) >= -MAX_CODE) |=> cur_a == $past(tgt_a));

    // R7: ramp modes never move more than one code per strobe.
    p_step_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1]) |=>
        ($signed(cur_a) <= $signed($past(cur_a)) + 1) &&
        ($signed(cur_a) + 1 >= $signed($past(cur_a))));

    // R9: applied gains stay inside the legal code range.
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(cur_a) <= MAX_CODE && $signed(cur_a) >= -MAX_CODE &&
        $signed(cur_b) <= MAX_CODE && $signed(cur_b) >= -MAX_CODE);

    // R12: without a strobe the applied gains hold.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cur_a) && $stable(cur_b));
endmodule

bind gain_ramp_ctrl gain_ramp_ctrl_chk #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tgt_a(tgt_a), .in_valid(in_valid),
    .out_valid(out_valid), .cur_a(cur_a), .cur_b(cur_b)
);

// File: tb/test_gain_ramp_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps codes and sample patterns in every mode
// against an arithmetic per-channel model built from the requirements.
module test_gain_ramp_ctrl;
    localparam int SW  = 16;
    localparam int CW  = 6;
    localparam int MAX = 24;
    localparam int TO  = 16;
    localparam int FW  = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] tgt_a = '0, tgt_b = '0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_a = '0, in_b = '0;
    logic          out_valid;
    logic [SW-1:0] out_a, out_b;
    logic [CW-1:0] cur_a, cur_b;
    logic          gain_settled;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int m_cur [2];
    int m_prev [2];
    int m_cnt [2];
    int m_tgt [2];

    always #4 clk = ~clk;

    gain_ramp_ctrl #(.SAMPLE_W(SW), .CODE_W(CW), .MAX_CODE(MAX), .TIMEOUT(TO), .FAC_W(FW))
    i_gain_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tgt_a(tgt_a), .tgt_b(tgt_b),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_a(out_a), .out_b(out_b), .cur_a(cur_a), .cur_b(cur_b),
        .gain_settled(gain_settled)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampc(input int t);
        if (t > MAX) return MAX;
        if (t < -MAX) return -MAX;
        return t;
    endfunction

    function automatic longint factor(input int k);
        longint f = 16384;
        if (k > 0) for (int i = 0; i < k; i++) f = (f * 17355) >>> 14;
        else       for (int i = 0; i < -k; i++) f = (f * 15467) >>> 14;
        return f;
    endfunction

    function automatic longint scale(input int s, input int k);
        longint r = (longint'(s) * factor(k)) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Model one channel's strobe update.
    task automatic model_step(input int c, input int s);
        bit zc = (s == 0) || ((s < 0) != (m_prev[c] < 0));
        int t = clampc(m_tgt[c]);
        int nxt;
        m_prev[c] = s;
        nxt = (t > m_cur[c]) ? m_cur[c] + 1 : m_cur[c] - 1;
        if (m_cur[c] == t) m_cnt[c] = 0;
        else if (!mode[0]) begin
            m_cur[c] = mode[1] ? nxt : t;
            m_cnt[c] = 0;
        end else if (zc || m_cnt[c] == TO - 1) begin
            m_cur[c] = mode[1] ? nxt : t;
            m_cnt[c] = 0;
        end else m_cnt[c]++;
    endtask

    task automatic set_tgt(input int a, input int b);
        m_tgt[0] = a;
        m_tgt[1] = b;
        tgt_a = CW'(a);
        tgt_b = CW'(b);
    endtask

    // One strobe, then compare every output one clock later.
    task automatic strobe(input int sa, input int sb, input string req);
        in_valid = 1'b1;
        in_a = SW'(sa);
        in_b = SW'(sb);
        model_step(0, sa);
        model_step(1, sb);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {req, " R2 valid"}, out_valid, 1);
        check($signed(cur_a) == m_cur[0], {req, " gain A"}, $signed(cur_a), m_cur[0]);
        check($signed(cur_b) == m_cur[1], {req, " R11 gain B"}, $signed(cur_b), m_cur[1]);
        check($signed(out_a) == scale(sa, m_cur[0]), {req, " R2 R3 out A"},
              $signed(out_a), scale(sa, m_cur[0]));
        check($signed(out_b) == scale(sb, m_cur[1]), {req, " R2 R3 out B"},
              $signed(out_b), scale(sb, m_cur[1]));
        check(gain_settled == (m_cur[0] == clampc(m_tgt[0]) && m_cur[1] == clampc(m_tgt[1])),
              {req, " R12 settled"}, gain_settled,
              (m_cur[0] == clampc(m_tgt[0]) && m_cur[1] == clampc(m_tgt[1])));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cur[c] = 0; m_prev[c] = 0; m_cnt[c] = 0; m_tgt[c] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(cur_a == '0 && cur_b == '0, "R1 gains", {cur_a, cur_b}, 0);
        check(out_a == '0 && out_b == '0, "R1 outputs", {out_a, out_b}, 0);
        check(gain_settled == 1'b1, "R1 settled", gain_settled, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R3: immediate mode, every code, full-scale and small samples.
        mode = 2'b00;
        for (int k = -MAX; k <= MAX; k++) begin
            set_tgt(k, -k);
            strobe(32767, -32768, "R4");
            strobe(-32768, 12345, "R4");
            strobe(-7777, 1, "R4");
            strobe(0, 3, "R4");
        end
        // R9: out-of-range targets clamp.
        set_tgt(31, -32);
        strobe(20000, 20000, "R9");
        set_tgt(-30, 29);
        strobe(-20000, 5, "R9");
        set_tgt(0, 0);
        strobe(100, 100, "R4");

        // R5 R6: zero-cross mode, timeout on A, sign flip on B.
        mode = 2'b01;
        set_tgt(10, -6);
        for (int i = 0; i < 20; i++) strobe(100 + i, (i < 5) ? 50 : -50, "R6 R5");
        set_tgt(-3, 7);
        strobe(0, -40, "R5");
        strobe(0, -40, "R5");
        strobe(300, 40, "R5");

        // R7 R10: ramp mode with a retarget mid-ramp.
        mode = 2'b10;
        set_tgt(24, -24);
        for (int i = 0; i < 20; i++) strobe((i * 3571) % 30000 - 15000, 9000 - i * 700, "R7");
        set_tgt(-5, 3);
        for (int i = 0; i < 60; i++) strobe(i * 511 - 15000, (i * 977) % 20000 - 10000, "R10");

        // R8 R6: ramp at crossings; A flips every 3 strobes, B never crosses.
        mode = 2'b11;
        set_tgt(-20, 20);
        for (int i = 0; i < 140; i++) strobe(((i / 3) % 2 == 0) ? 4000 : -4000, 200 + i, "R8");

        // R12: no strobe, new targets, gains must hold.
        mode = 2'b00;
        set_tgt(12, -12);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R2 R12 idle valid", out_valid, 0);
            check($signed(cur_a) == m_cur[0] && $signed(cur_b) == m_cur[1],
                  "R12 hold", $signed(cur_a), m_cur[0]);
        end
        strobe(1000, -1000, "R4 R12");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule